// File: doc/BRIEF.md
# DS1-to-E1 Backplane Timeslot Mapper

This block carries a DS1 payload of 24 DS0 channels on a backplane serial stream laid out as an E1 frame. Each 125 µs frame has 32 timeslots of eight bits, or 256 bit periods at the base 2.048 MHz rate. Three of every four timeslots carry a DS0 channel. Every fourth timeslot, starting at timeslot 0, holds no channel and is filled with ones. The block fetches channel bytes from an external frame buffer through an index/byte pair. It requests each byte one timeslot early, so the byte is ready when its slot starts.

The block drives two sync pulses, each one clock wide, on the first clock of the first bit of a frame. The frame pulse marks every frame. The multiframe pulse marks only the first frame of a DS1 multiframe, which is 24 frames by default or 12 when set by parameter. A parameter holds each bit for 2 or 4 clocks, for 4.096 MHz or 8.192 MHz backplane clocking. A static input picks whether the outputs change on the rising or the falling clock edge.

Top module: `ds1_slot_mapper`

## Requirements
- R1: A frame lasts 32 × 8 × CLK_DIV clocks. Each serial bit is held for CLK_DIV clocks, where CLK_DIV is 1, 2 or 4.
- R2: frameSync is high for exactly one clock. That clock is the first clock of bit 0 of timeslot 0 of every frame.
- R3: Timeslots whose index is a multiple of 4 (0, 4, ..., 28) carry no channel and drive serData high for all eight bits.
- R4: mfSync is high for exactly one clock, together with frameSync, on the first frame of each multiframe of MF_FRAMES frames.
- R5: A timeslot s that is not a multiple of 4 carries channel s − floor(s/4), which gives channels 1 to 24 in ascending order. The bits go out most significant bit first.
- R6: During timeslot s, chanIdx shows the channel of timeslot (s+1) mod 32, or 0 when that slot is idle. chanByte is taken on the last clock of timeslot s.
- R7: With txFalling = 0, serData, frameSync and mfSync change just after the rising edge. With txFalling = 1 they change on the falling edge, half a clock later.
- R8: While the synchronous reset rst is high, serData is 1 and frameSync and mfSync are 0. On the first clock after rst is released, both frameSync and mfSync are high, and the frame starts again from timeslot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Backplane serial clock |
| rst | input | 1 | Synchronous reset, active high |
| txFalling | input | 1 | Static edge select: 0 updates outputs on the rising edge, 1 on the falling edge |
| chanIdx | output | 5 | Channel requested for the next timeslot (1..24), or 0 when the next slot is idle |
| chanByte | input | 8 | Byte of the requested channel, from the frame buffer |
| serData | output | 1 | Backplane serial data |
| frameSync | output | 1 | One-clock frame start pulse |
| mfSync | output | 1 | One-clock multiframe start pulse |

## Verification
Some properties are checked on every cycle. These are: the frame pulse is one clock wide and recurs at exactly the frame length; the multiframe pulse never occurs without the frame pulse; idle slots stay high; serData holds steady within a bit; the requested index stays in range; and both pulses fire right after reset. Other behaviour is shown only by the bench's scenarios, which compare every output on every clock against an independent frame model. These scenarios cover which channel lands in which slot and in what bit order, the one-slot-early byte request, the multiframe length, the half-cycle delay of falling-edge mode, and the restart after a reset in mid-frame.

// File: rtl/ds1map_pkg.sv
package ds1map_pkg;
  localparam int NUM_SLOTS   = 32;
  localparam int SLOT_BITS   = 8;
  localparam int NUM_CHANS   = 24;
  localparam int IDLE_STRIDE = 4;

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int CHAN_W = $clog2(NUM_CHANS + 1);

  // Strobes from the sequencer to the serializer
  typedef struct packed {
    logic bitAdv;    // last clock of the current bit
    logic slotLoad;  // last clock of the current slot
    logic loadIdle;  // slot about to start carries no channel
    logic frameMark; // first clock of a frame
    logic mfMark;    // first clock of a multiframe
  } ctrl_strobe_t;
endpackage

// File: rtl/ds1map_ctrl.sv
module ds1map_ctrl
  import ds1map_pkg::*;
#(
  parameter int CLK_DIV   = 1,
  parameter int MF_FRAMES = 24,
  localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int FRAME_W  = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output ctrl_strobe_t      strb,
  output logic [CHAN_W-1:0] chanIdx,
  output logic [SLOT_W-1:0] slotNow,
  output logic [DIV_W-1:0]  divNow
);
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [SLOT_W-1:0]  slotCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic [SLOT_W-1:0]  nextSlot;
  logic               bitEnd, slotEnd, frameEnd, nextIdle;

  assign bitEnd   = (divCnt == DIV_W'(CLK_DIV - 1));
  assign slotEnd  = bitEnd && (bitCnt == BIT_W'(SLOT_BITS - 1));
  assign frameEnd = slotEnd && (slotCnt == SLOT_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      slotCnt  <= '0;
      frameCnt <= '0;
    end else begin
      divCnt <= bitEnd ? '0 : divCnt + DIV_W'(1);
      if (bitEnd)
        bitCnt <= slotEnd ? '0 : bitCnt + BIT_W'(1);
      if (slotEnd)
        slotCnt <= frameEnd ? '0 : slotCnt + SLOT_W'(1);
      if (frameEnd)
        frameCnt <= (frameCnt == FRAME_W'(MF_FRAMES - 1)) ? '0 : frameCnt + FRAME_W'(1);
    end
  end

  // Look one slot ahead for the channel request
  always_comb begin
    nextSlot = (slotCnt == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slotCnt + SLOT_W'(1);
    nextIdle = (int'(nextSlot) % IDLE_STRIDE) == 0;
    chanIdx  = nextIdle ? '0
                        : CHAN_W'(int'(nextSlot) - int'(nextSlot) / IDLE_STRIDE);
  end

  always_comb begin
    strb.bitAdv    = bitEnd;
    strb.slotLoad  = slotEnd;
    strb.loadIdle  = nextIdle;
    strb.frameMark = (divCnt == '0) && (bitCnt == '0) && (slotCnt == '0);
    strb.mfMark    = strb.frameMark && (frameCnt == '0);
  end

  assign slotNow = slotCnt;
  assign divNow  = divCnt;
endmodule

// File: rtl/ds1map_dpath.sv
module ds1map_dpath
  import ds1map_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txFalling,
  input  ctrl_strobe_t         strb,
  input  logic [SLOT_BITS-1:0] chanByte,
  output logic                 serData,
  output logic                 frameSync,
  output logic                 mfSync
);
  logic [SLOT_BITS-1:0] shiftReg;
  logic posData, posFrame, posMf;
  logic negData, negFrame, negMf;

  // Slot 0 is idle, so the register starts full of ones
  always_ff @(posedge clk) begin
    if (rst)
      shiftReg <= '1;
    else if (strb.slotLoad)
      shiftReg <= strb.loadIdle ? '1 : chanByte;
    else if (strb.bitAdv)
      shiftReg <= {shiftReg[SLOT_BITS-2:0], 1'b1};
  end

  assign posData  = shiftReg[SLOT_BITS-1];
  assign posFrame = strb.frameMark & ~rst;
  assign posMf    = strb.mfMark & ~rst;

  // Half-cycle retimed copy for falling-edge launch
  always_ff @(negedge clk) begin
    if (rst) begin
      negData  <= 1'b1;
      negFrame <= 1'b0;
      negMf    <= 1'b0;
    end else begin
      negData  <= posData;
      negFrame <= posFrame;
      negMf    <= posMf;
    end
  end

  assign serData   = txFalling ? negData  : posData;
  assign frameSync = txFalling ? negFrame : posFrame;
  assign mfSync    = txFalling ? negMf    : posMf;
endmodule

// File: rtl/ds1_slot_mapper.sv
module ds1_slot_mapper
  import ds1map_pkg::*;
#(
  parameter int CLK_DIV   = 1,
  parameter int MF_FRAMES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txFalling,
  output logic [CHAN_W-1:0] chanIdx,
  input  logic [7:0]        chanByte,
  output logic              serData,
  output logic              frameSync,
  output logic              mfSync
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  ctrl_strobe_t      strb;
  logic [SLOT_W-1:0] slotNow;
  logic [DIV_W-1:0]  divNow;

  ds1map_ctrl #(.CLK_DIV(CLK_DIV), .MF_FRAMES(MF_FRAMES)) u_ctrl (
    .clk(clk), .rst(rst), .strb(strb), .chanIdx(chanIdx),
    .slotNow(slotNow), .divNow(divNow)
  );

  ds1map_dpath u_dpath (
    .clk(clk), .rst(rst), .txFalling(txFalling), .strb(strb),
    .chanByte(chanByte), .serData(serData), .frameSync(frameSync), .mfSync(mfSync)
  );
endmodule

// File: rtl/ds1map_checker.sv
module ds1map_checker
  import ds1map_pkg::*;
#(
  parameter int CLK_DIV   = 1,
  parameter int MF_FRAMES = 24,
  localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              txFalling,
  input logic [CHAN_W-1:0] chanIdx,
  input logic              serData,
  input logic              frameSync,
  input logic              mfSync,
  input logic [SLOT_W-1:0] slotNow,
  input logic [DIV_W-1:0]  divNow
);
  localparam int FRAME_CLKS = NUM_SLOTS * SLOT_BITS * CLK_DIV;

  int   gapCnt;
  logic seenSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= 0;
      seenSync <= 1'b0;
    end else if (frameSync) begin
      gapCnt   <= 0;
      seenSync <= 1'b1;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  a_r1_frame_period: assert property (@(posedge clk) disable iff (rst)
    (frameSync && seenSync) |-> (gapCnt == FRAME_CLKS - 1));

  a_r1_bit_held: assert property (@(posedge clk) disable iff (rst)
    (!txFalling && divNow != '0) |-> $stable(serData));

  a_r2_frame_single: assert property (@(posedge clk) disable iff (rst)
    frameSync |=> !frameSync);

  a_r3_idle_ones: assert property (@(posedge clk) disable iff (rst)
    (!txFalling && slotNow[1:0] == 2'b00) |-> serData);

  a_r4_mf_with_frame: assert property (@(posedge clk) disable iff (rst)
    mfSync |-> frameSync);

  a_r6_chan_range: assert property (@(posedge clk) disable iff (rst)
    chanIdx <= CHAN_W'(NUM_CHANS));

  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (frameSync && mfSync));
endmodule

bind ds1_slot_mapper ds1map_checker #(.CLK_DIV(CLK_DIV), .MF_FRAMES(MF_FRAMES)) u_chk (
  .clk(clk), .rst(rst), .txFalling(txFalling), .chanIdx(chanIdx),
  .serData(serData), .frameSync(frameSync), .mfSync(mfSync),
  .slotNow(slotNow), .divNow(divNow)
);

// File: tb/test_ds1_slot_mapper.sv
module test_ds1_slot_mapper;
  localparam int DIV_A = 1, MF_A = 24;
  localparam int DIV_B = 2, MF_B = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fallA = 1'b0, fallB = 1'b0;
  logic [7:0] pat = 8'h00;
  logic [4:0] chanA, chanB;
  logic [7:0] byteA, byteB;
  logic       dataA, fsA, mfA, dataB, fsB, mfB;
  int         nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] byteOf(int ch, logic [7:0] p);
    return 8'(ch * 37) ^ p;
  endfunction

  assign byteA = byteOf(int'(chanA), pat);
  assign byteB = byteOf(int'(chanB), pat);

  ds1_slot_mapper #(.CLK_DIV(DIV_A), .MF_FRAMES(MF_A)) i_ds1_slot_mapper (
    .clk(clk), .rst(rst), .txFalling(fallA), .chanIdx(chanA), .chanByte(byteA),
    .serData(dataA), .frameSync(fsA), .mfSync(mfA)
  );

  ds1_slot_mapper #(.CLK_DIV(DIV_B), .MF_FRAMES(MF_B)) i_ds1_slot_mapper_b (
    .clk(clk), .rst(rst), .txFalling(fallB), .chanIdx(chanB), .chanByte(byteB),
    .serData(dataB), .frameSync(fsB), .mfSync(mfB)
  );

  // Independent frame model, k = clocks since reset release
  function automatic logic expData(int k, int div, logic [7:0] p);
    int bitIdx = k / div;
    int slot = (bitIdx / 8) % 32;
    int b = bitIdx % 8;
    logic [7:0] v;
    if (slot % 4 == 0) return 1'b1;
    v = byteOf(slot - slot / 4, p);
    return v[7 - b];
  endfunction

  function automatic logic expFs(int k, int div);
    return (k % (256 * div)) == 0;
  endfunction

  function automatic logic expMf(int k, int div, int mf);
    return (k % (256 * div * mf)) == 0;
  endfunction

  function automatic int expChan(int k, int div);
    int slot = (k / div / 8) % 32;
    int ns = (slot + 1) % 32;
    return (ns % 4 == 0) ? 0 : ns - ns / 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Checks one instance: late = sample before the next rising edge
  task automatic checkLate(int k, int div, int mf, logic d, logic fs, logic m, logic [4:0] ch);
    chk("R5/R3 serData", int'(d), int'(expData(k, div, pat)));
    chk("R2 frameSync", int'(fs), int'(expFs(k, div)));
    chk("R4 mfSync", int'(m), int'(expMf(k, div, mf)));
    chk("R6 chanIdx", int'(ch), expChan(k, div));
  endtask

  // Early sample just after the rising edge: falling mode still shows cycle k-1
  task automatic checkEarly(int k, int div, int mf, logic fall, logic d, logic fs, logic m);
    int ke = fall ? k - 1 : k;
    chk("R7 serData edge", int'(d), int'(expData(ke, div, pat)));
    chk("R7 frameSync edge", int'(fs), int'(expFs(ke, div)));
    chk("R7 mfSync edge", int'(m), int'(expMf(ke, div, mf)));
  endtask

  task automatic holdReset(int n, logic fa, logic fb);
    @(posedge clk); #2;
    rst = 1'b1; fallA = fa; fallB = fb;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #7;
      chk("R8 reset serData A", int'(dataA), 1);
      chk("R8 reset frameSync A", int'(fsA), 0);
      chk("R8 reset mfSync A", int'(mfA), 0);
      chk("R8 reset serData B", int'(dataB), 1);
      chk("R8 reset frameSync B", int'(fsB), 0);
      chk("R8 reset mfSync B", int'(mfB), 0);
    end
  endtask

  task automatic runFrames(int n);
    @(posedge clk); #2;
    rst = 1'b0;
    #5;
    chk("R8 first pulse A", int'(fsA & mfA), 1);
    chk("R8 first pulse B", int'(fsB & mfB), 1);
    checkLate(0, DIV_A, MF_A, dataA, fsA, mfA, chanA);
    checkLate(0, DIV_B, MF_B, dataB, fsB, mfB, chanB);
    for (int k = 1; k < n; k++) begin
      @(posedge clk); #1;
      checkEarly(k, DIV_A, MF_A, fallA, dataA, fsA, mfA);
      checkEarly(k, DIV_B, MF_B, fallB, dataB, fsB, mfB);
      #6;
      checkLate(k, DIV_A, MF_A, dataA, fsA, mfA, chanA);
      checkLate(k, DIV_B, MF_B, dataB, fsB, mfB, chanB);
    end
  endtask

  // R1 R2 R3 R4 R5 R6: two full multiframes of both instances, rising edge
  task automatic scenarioRisingMultiframe();
    pat = 8'h00;
    holdReset(3, 1'b0, 1'b0);
    runFrames(2 * 256 * DIV_A * MF_A + 20);
  endtask

  // R7: falling-edge launch on both instances with another byte pattern
  task automatic scenarioFallingEdge();
    pat = 8'hA5;
    holdReset(2, 1'b1, 1'b1);
    runFrames(3 * 256 * DIV_B + 10);
  endtask

  // R8: reset in mid-frame, mixed edges, restart from slot 0
  task automatic scenarioMidReset();
    pat = 8'h3C;
    holdReset(2, 1'b0, 1'b1);
    runFrames(777);
    holdReset(3, 1'b1, 1'b0);
    runFrames(2 * 256 * DIV_B + 40);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    scenarioRisingMultiframe();
    scenarioFallingEdge();
    scenarioMidReset();
    finishRun();
  end
endmodule